// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers one-cycle event pulses from a peripheral's two timers and its shift register, latches each in a bit of a byte-wide flag register, and gates them with a byte-wide enable register. It drives a single level-sensitive interrupt line. Software reaches both registers through a small register bus. A write to the flag register clears flags. A write to the enable register sets or clears enables, as bit 7 of the written byte selects. Reads of the flag register carry a synthesised summary in bit 7.

The neighbouring registers of the peripheral also send clear strobes: reading a timer's low counter byte acknowledges that timer, and reading the shift register acknowledges the shift flags. Events are never lost. A set pulse that meets a clear in the same cycle leaves the flag set.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset both registers are zero: a flag read returns 0x00, an enable read returns 0x80 and `irq` is low.
- R2: A write to the enable address (2) with bit 7 = 1 ORs written bits 6:0 into the enables.
- R3: A write to the enable address with bit 7 = 0 clears every enable whose written bit is 1 and keeps the others.
- R4: An enable read always returns bit 7 as 1, with the enables in bits 6:0.
- R5: Event pulses set flags at fixed positions: timer 1 on bit 6, timer 2 on bit 5, shift-clock on bit 4, shift-data on bit 3, shift on bit 2. A flag holds until it is cleared.
- R6: A write to the flag address (1) clears each flag bit written as 1. Bit 7 of the written byte and the zero bits have no effect.
- R7: `t1_ack` clears bit 6, `t2_ack` clears bit 5, and `sh_ack` clears bits 4, 3 and 2 together.
- R8: A flag read returns the flags in bits 6:0, with bit 7 set exactly when flags AND enables is nonzero over bits 6:0. Other addresses (0, 3) read as 0x00.
- R9: `irq` is high exactly when flags AND enables has bit 6, 5 or 2 set. Bits 4 and 3 never raise it. It follows the register state with no extra delay: it changes in the cycle after the edge that changes the state.
- R10: When a set pulse and any clear (bus write or strobe) hit the same bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 2 | Register select: 1 flags, 2 enables |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| t1_evt | input | 1 | Timer 1 event pulse |
| t2_evt | input | 1 | Timer 2 event pulse |
| sh_evt | input | 1 | Shift-register complete pulse |
| sh_dat_evt | input | 1 | Shift data event pulse |
| sh_clk_evt | input | 1 | Shift clock event pulse |
| t1_ack | input | 1 | Clear strobe for the timer 1 flag |
| t2_ack | input | 1 | Clear strobe for the timer 2 flag |
| sh_ack | input | 1 | Clear strobe for the three shift flags |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a set pulse that meets a clear of the same bit in the same cycle, from a bus write or from an acknowledge strobe. Directed steps drive each pairing explicitly, and a long random phase makes such collisions frequent on all bits. A behavioural model checks read data and `irq` every cycle. A second hard case is the split between the summary bit and the interrupt line. Enabling only the shift data and clock bits shows the summary rising while `irq` stays low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = DATA_W - 1;

  localparam int BIT_T1    = 6;
  localparam int BIT_T2    = 5;
  localparam int BIT_SHCLK = 4;
  localparam int BIT_SHDAT = 3;
  localparam int BIT_SH    = 2;

  // Bits allowed to drive the interrupt line
  localparam logic [FLAG_W-1:0] IRQ_SRC_MASK =
    FLAG_W'((1 << BIT_T1) | (1 << BIT_T2) | (1 << BIT_SH));
  // Bits dropped by a shift acknowledge
  localparam logic [FLAG_W-1:0] SH_ACK_MASK =
    FLAG_W'((1 << BIT_SHCLK) | (1 << BIT_SHDAT) | (1 << BIT_SH));

  // Top bit of an enable write selects OR-in versus knock-out
  function automatic logic [FLAG_W-1:0] enable_next(
    input logic [FLAG_W-1:0] cur, input logic [DATA_W-1:0] wd);
    return wd[DATA_W-1] ? (cur | wd[FLAG_W-1:0]) : (cur & ~wd[FLAG_W-1:0]);
  endfunction

  function automatic logic any_pending(
    input logic [FLAG_W-1:0] flg, input logic [FLAG_W-1:0] ena,
    input logic [FLAG_W-1:0] msk);
    return |(flg & ena & msk);
  endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flag_q
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (set_vec[i]) bit_q <= 1'b1;   // set outranks clear
      else if (clr_vec[i]) bit_q <= 1'b0;
    end
    assign flag_q[i] = bit_q;
  end
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [FLAG_W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= enable_next(en_q, wdata);
  end
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
  import irqc_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 1,
  parameter logic [ADDR_W-1:0] ENAB_ADDR = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [FLAG_W-1:0] flag_q,
  input  logic [FLAG_W-1:0] en_q,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    if (addr == FLAG_ADDR)
      rd_data = {any_pending(flag_q, en_q, '1), flag_q};
    else if (addr == ENAB_ADDR)
      rd_data = {1'b1, en_q};
    else
      rd_data = '0;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 1,
  parameter logic [ADDR_W-1:0] ENAB_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              t1_evt,
  input  logic              t2_evt,
  input  logic              sh_evt,
  input  logic              sh_dat_evt,
  input  logic              sh_clk_evt,
  input  logic              t1_ack,
  input  logic              t2_ack,
  input  logic              sh_ack,
  output logic              irq
);
  // Named internal events, visible to the bound checker
  logic              flag_wr;
  logic              enab_wr;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] en_q;

  assign flag_wr = wr_en && (addr == FLAG_ADDR);
  assign enab_wr = wr_en && (addr == ENAB_ADDR);

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_T1]    = t1_evt;
    set_vec[BIT_T2]    = t2_evt;
    set_vec[BIT_SHCLK] = sh_clk_evt;
    set_vec[BIT_SHDAT] = sh_dat_evt;
    set_vec[BIT_SH]    = sh_evt;

    clr_vec = flag_wr ? wr_data[FLAG_W-1:0] : '0;
    if (t1_ack) clr_vec[BIT_T1] = 1'b1;
    if (t2_ack) clr_vec[BIT_T2] = 1'b1;
    if (sh_ack) clr_vec = clr_vec | SH_ACK_MASK;
  end

  irqc_flag_bank #(.W(FLAG_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flag_q  (flag_q)
  );

  irqc_enable_reg u_enab (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (enab_wr),
    .wdata (wr_data),
    .en_q  (en_q)
  );

  irqc_read_mux #(
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .ENAB_ADDR (ENAB_ADDR)
  ) u_rmux (
    .addr    (addr),
    .flag_q  (flag_q),
    .en_q    (en_q),
    .rd_data (rd_data)
  );

  assign irq = any_pending(flag_q, en_q, IRQ_SRC_MASK);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 1,
  parameter logic [ADDR_W-1:0] ENAB_ADDR = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              flag_wr,
  input logic              enab_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic [FLAG_W-1:0] set_vec,
  input logic [FLAG_W-1:0] clr_vec,
  input logic [FLAG_W-1:0] flag_q,
  input logic [FLAG_W-1:0] en_q,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq
);
  // R2: OR-in write
  a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_wr && wr_data[7]) |=> (en_q == ($past(en_q) | $past(wr_data[6:0]))));

  // R3: knock-out write
  a_r3_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_wr && !wr_data[7]) |=> (en_q == ($past(en_q) & ~$past(wr_data[6:0]))));

  // R4: enable read top bit
  a_r4_enable_top: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ENAB_ADDR) |-> rd_data[7]);

  // R5: a flag with no clear holds
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~clr_vec) != '0) |=>
      ((flag_q & $past(flag_q & ~clr_vec)) == $past(flag_q & ~clr_vec)));

  // R6: flag write without a colliding set leaves written bits clear
  a_r6_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && (set_vec == '0)) |=> ((flag_q & $past(wr_data[6:0])) == '0));

  // R8: no pending means summary bit low
  a_r8_summary_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr == FLAG_ADDR) && ((flag_q & en_q) == '0)) |-> !rd_data[7]);

  // R9: no interrupt without a routed enable
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & IRQ_SRC_MASK) == '0) |-> !irq);

  // R10: set wins over a same-cycle clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=>
      ((flag_q & $past(set_vec)) == $past(set_vec)));
endmodule

bind irq_flag_ctrl irqc_checker #(
  .ADDR_W    (ADDR_W),
  .FLAG_ADDR (FLAG_ADDR),
  .ENAB_ADDR (ENAB_ADDR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .flag_wr (flag_wr),
  .enab_wr (enab_wr),
  .wr_data (wr_data),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .flag_q  (flag_q),
  .en_q    (en_q),
  .rd_data (rd_data),
  .irq     (irq)
);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic t1_evt, t2_evt, sh_evt, sh_dat_evt, sh_clk_evt;
  logic t1_ack, t2_ack, sh_ack;
  logic irq;

  always #2 clk = ~clk;   // 250 MHz

  irq_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .t1_evt(t1_evt), .t2_evt(t2_evt), .sh_evt(sh_evt),
    .sh_dat_evt(sh_dat_evt), .sh_clk_evt(sh_clk_evt), .t1_ack(t1_ack),
    .t2_ack(t2_ack), .sh_ack(sh_ack), .irq(irq)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // Behavioural reference: integers, updated every edge
  int m_flag, m_en;
  always @(posedge clk) begin
    int s, c;
    if (!rst_n) begin
      m_flag <= 0;
      m_en   <= 0;
    end else begin
      s = (t1_evt << 6) | (t2_evt << 5) | (sh_clk_evt << 4) | (sh_dat_evt << 3) | (sh_evt << 2);
      c = 0;
      if (wr_en && addr == 2'd1) c = wr_data & 8'h7f;
      if (t1_ack) c = c | 8'h40;
      if (t2_ack) c = c | 8'h20;
      if (sh_ack) c = c | 8'h1c;
      m_flag <= ((m_flag & ~c) | s) & 8'h7f;
      if (wr_en && addr == 2'd2)
        m_en <= wr_data[7] ? (m_en | (wr_data & 8'h7f)) : (m_en & ~wr_data & 8'h7f);
    end
  end

  task automatic compare();
    int exp_rd;
    bit exp_irq;
    if (addr == 2'd1)      exp_rd = m_flag | (((m_flag & m_en) != 0) ? 8'h80 : 0);
    else if (addr == 2'd2) exp_rd = m_en | 8'h80;
    else                   exp_rd = 0;
    exp_irq = (m_flag & m_en & 8'h64) != 0;
    n_chk++;
    if (rd_data !== 8'(exp_rd) || irq !== exp_irq) begin
      n_fail++;
      $display("FAIL %s: addr=%0d rd_data=%02h irq=%b expected rd_data=%02h irq=%b",
               cur_req, addr, rd_data, irq, 8'(exp_rd), exp_irq);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_data = 0;
    t1_evt = 0; t2_evt = 0; sh_evt = 0; sh_dat_evt = 0; sh_clk_evt = 0;
    t1_ack = 0; t2_ack = 0; sh_ack = 0;
  endtask

  // One clock, then check with the inputs of that clock still applied
  task automatic cyc();
    @(posedge clk); #1;
    compare();
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_en = 1; wr_data = d; cyc();
  endtask

  task automatic look(input logic [1:0] a);
    addr = a; #1; compare();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(); addr = 2'd1; rst_n = 0;
    // R1: reset state
    cur_req = "R1";
    cyc(); cyc();
    rst_n = 1;
    look(2'd1); look(2'd2); look(2'd0); look(2'd3);

    // R5: each source sets its own bit; no enables so no irq
    cur_req = "R5";
    addr = 2'd1; t1_evt = 1; cyc();
    cyc(); look(2'd1);
    t2_evt = 1; cyc();
    sh_evt = 1; cyc();
    sh_dat_evt = 1; cyc();
    sh_clk_evt = 1; cyc();
    look(2'd1);

    // R6: flag write clears only the 1 bits; bit 7 of data has no effect
    cur_req = "R6";
    wr(2'd1, 8'h88);  look(2'd1);
    wr(2'd1, 8'h00);  look(2'd1);
    wr(2'd1, 8'h7f);  look(2'd1);

    // R2 / R4: OR-in enables
    cur_req = "R2";
    wr(2'd2, 8'hc0); look(2'd2);
    wr(2'd2, 8'h84); look(2'd2);
    cur_req = "R4";
    look(2'd2);

    // R9 / R8: timer 1 event raises irq and summary
    cur_req = "R9";
    addr = 2'd1; t1_evt = 1; cyc();
    look(2'd1);
    cur_req = "R3";
    wr(2'd2, 8'h40); look(2'd2); look(2'd1);
    wr(2'd2, 8'h00); look(2'd2);

    // R8: shift data/clock flags raise summary but never irq (R9)
    cur_req = "R8";
    wr(2'd2, 8'h98);
    addr = 2'd1; sh_dat_evt = 1; cyc();
    sh_clk_evt = 1; cyc();
    look(2'd1);
    cur_req = "R9";
    look(2'd1);

    // R7: acknowledge strobes
    cur_req = "R7";
    wr(2'd2, 8'hff);
    addr = 2'd1; t1_evt = 1; t2_evt = 1; sh_evt = 1; cyc();
    t1_ack = 1; cyc(); look(2'd1);
    sh_ack = 1; cyc(); look(2'd1);
    t2_ack = 1; cyc(); look(2'd1);

    // R10: set meets clear in the same cycle
    cur_req = "R10";
    addr = 2'd1; t2_evt = 1; t2_ack = 1; cyc(); look(2'd1);
    sh_evt = 1; sh_ack = 1; cyc(); look(2'd1);
    addr = 2'd1; wr_en = 1; wr_data = 8'h7f; t1_evt = 1; cyc(); look(2'd1);
    wr(2'd1, 8'h7f); look(2'd1);

    // Mixed random traffic, model compared each cycle
    cur_req = "R10";
    for (int k = 0; k < 4000; k++) begin
      addr       = 2'($urandom_range(0, 3));
      wr_en      = ($urandom_range(0, 3) == 0);
      wr_data    = 8'($urandom);
      t1_evt     = ($urandom_range(0, 3) == 0);
      t2_evt     = ($urandom_range(0, 3) == 0);
      sh_evt     = ($urandom_range(0, 3) == 0);
      sh_dat_evt = ($urandom_range(0, 5) == 0);
      sh_clk_evt = ($urandom_range(0, 5) == 0);
      t1_ack     = ($urandom_range(0, 3) == 0);
      t2_ack     = ($urandom_range(0, 3) == 0);
      sh_ack     = ($urandom_range(0, 3) == 0);
      cyc();
    end

    // R1: reset again from a busy state
    cur_req = "R1";
    wr(2'd2, 8'hff);
    rst_n = 0; cyc(); rst_n = 1;
    look(2'd1); look(2'd2);

    finish_run();
  end
endmodule